// File: doc/BRIEF.md
# Sector Erase Sequencer with Acceptance Window and Suspend

This block runs the sector-erase side of a byte-wide flash model. A command decoder sends it an erase request that names a sector. The block opens an acceptance window, and further erase requests for other sectors join the same operation while that window is open. Each joining request starts the window count again. When the window runs out, the block erases every collected sector one after another, lowest sector number first. For each sector it writes every byte to 00h, runs a counted erase pulse, and then writes every byte to FFh. Cell physics is not modelled. A sector can be marked as failing, which makes its erase pulse repeat until a try limit is reached and the block reports an error.

While the block is busy, reads return a status byte instead of array data. The status byte carries a data-poll bit, a toggle bit, an error bit and an erase-timer bit. An erase can be suspended. While suspended, the toggle bit is frozen, sectors that are not part of the erase read back normally, and array writes are refused. A resume continues the erase exactly where it stopped. A suspend sent during the acceptance window closes the window without starting the erase.

The controller is one state machine with seven states:
- READ: array access.
- WIN: acceptance window.
- ZERO: 00h pre-fill of the current sector.
- PULSE: counted erase pulse.
- FILL: FFh fill of the current sector.
- SUSP: suspended.
- FAIL: erase error.

The transitions are:
- READ to WIN on an erase request.
- WIN to WIN on a further erase request.
- WIN to ZERO on window expiry.
- WIN to SUSP on suspend.
- WIN to READ on any other command except resume.
- ZERO to PULSE after the last byte.
- PULSE to PULSE on a retry.
- PULSE to FILL when the sector verifies.
- PULSE to FAIL at the try limit.
- FILL to ZERO when more sectors remain.
- FILL to READ after the last sector.
- ZERO, PULSE or FILL to SUSP on suspend.
- ZERO, PULSE or FILL to READ on reset.
- SUSP back to the interrupted state on resume.
- SUSP to READ on reset.
- FAIL to READ on reset.

Top module: `sec_erase_ctl`

## Requirements
- R1: After reset the block is in read mode with no sector selected, and every array byte reads FFh.
- R2: Reads have one cycle of latency. rd_data reflects the state in the cycle rd_en is high and appears after that clock edge. In read mode, cmd_op 5 (program) writes cmd_data to cmd_addr, and a later read returns it.
- R3: cmd_op 1 (erase) in read mode selects the sector cmd_addr[AW-1:SECT_AW] and opens the window. Status reads during the window have bit 3 (timer) = 0 and bit 7 (poll) = 0.
- R4: An erase request inside the window adds its sector and restarts the count. The ZERO state begins WINDOW_CYC edges after the edge that took the last erase request. From then on, status bit 3 reads 1.
- R5: In the window, any command other than erase (1), suspend (2) or resume (3) returns the block to read mode. No sector is erased and the aborting command has no effect on the array.
- R6: Each selected sector is pre-filled to 00h (2^SECT_AW cycles), pulsed (ERASE_CYC cycles) and filled to FFh (2^SECT_AW cycles). Selected sectors are handled lowest index first, the block then returns to read mode, and unselected sectors keep their data.
- R7: Status bit 6 (toggle) inverts on each successive status read while an operation is active.
- R8: During ZERO, PULSE and FILL, cmd_op 4 (reset) returns to read mode at once. Commands other than reset and suspend are ignored and do not change the erase timing.
- R9: While suspended, the toggle bit holds its value, status bit 7 reads 0 and bit 3 reads 1. Reads of selected sectors return status, reads of other sectors return array data, program commands are refused, and only resume and reset are accepted.
- R10: cmd_op 3 (resume) continues the interrupted state with its counters unchanged. Completion is delayed by exactly the edges spent from the suspend edge to the resume edge, inclusive.
- R11: A suspend during the window ends the window. Erasing starts only on the resume edge, and completes 2*2^SECT_AW+ERASE_CYC edges after it for a single sector.
- R12: A sector flagged in fail_sect repeats its pulse. After MAX_TRY pulses the block enters FAIL, where status bit 5 (error) = 1, and it stays there until a reset command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from the decoder |
| cmd_op | input | 3 | Command code: 1 erase, 2 suspend, 3 resume, 4 reset, 5 program; other values count as other commands |
| cmd_addr | input | AW | Byte address; the upper bits name the sector |
| cmd_data | input | 8 | Program data |
| fail_sect | input | NUM_SECT | Sectors whose erase never verifies |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 8 | Array byte or status byte, registered |

## Verification
The bench builds the block with 4 sectors of 8 bytes, a 12-cycle window, a 6-cycle pulse and a 3-try limit. With these values the bench can predict a whole multi-sector erase, a retry-to-failure sequence and a restarted window exactly to the edge. It then samples status and data one cycle on each side of every predicted transition. The small sectors let a suspend be placed inside the second sector's pre-fill, so the bench can observe the lowest-first order and the resume-timing arithmetic. The short window lets a restart be told apart from the original expiry.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

    localparam int DW = 8;

    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_WIN   = 3'd1,
        ST_ZERO  = 3'd2,
        ST_PULSE = 3'd3,
        ST_FILL  = 3'd4,
        ST_SUSP  = 3'd5,
        ST_FAIL  = 3'd6
    } sec_state_t;

    localparam logic [2:0] OP_ERASE  = 3'd1;
    localparam logic [2:0] OP_SUSP   = 3'd2;
    localparam logic [2:0] OP_RESUME = 3'd3;
    localparam logic [2:0] OP_RESET  = 3'd4;
    localparam logic [2:0] OP_PROG   = 3'd5;

    // status byte: poll 7, toggle 6, error 5, timer 3
    function automatic logic [DW-1:0] status_byte(input logic tog, input logic err,
                                                  input logic tmr);
        return {1'b0, tog, err, 1'b0, tmr, 3'b000};
    endfunction

endpackage

// File: rtl/sec_window_timer.sv
module sec_window_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && !restart && (cnt_q == LAST);
endmodule

// File: rtl/sec_low_pick.sv
module sec_low_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sec_byte_array.sv
module sec_byte_array #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sec_erase_ctl.sv
module sec_erase_ctl
    import sec_erase_pkg::*;
#(
    parameter int NUM_SECT   = 8,
    parameter int SECT_AW    = 4,
    parameter int WINDOW_CYC = 10000,
    parameter int ERASE_CYC  = 4096,
    parameter int MAX_TRY    = 4,
    parameter int SW         = $clog2(NUM_SECT),
    parameter int AW         = SW + SECT_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [AW-1:0]       cmd_addr,
    input  logic [DW-1:0]       cmd_data,
    input  logic [NUM_SECT-1:0] fail_sect,
    input  logic                rd_en,
    input  logic [AW-1:0]       rd_addr,
    output logic [DW-1:0]       rd_data
);
    localparam int DEPTH = NUM_SECT << SECT_AW;
    localparam int PCW   = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;
    localparam int TRW   = (MAX_TRY > 1) ? $clog2(MAX_TRY) : 1;
    localparam logic [SECT_AW-1:0] BA_LAST = '1;
    localparam logic [PCW-1:0]     PC_LAST = PCW'(ERASE_CYC - 1);
    localparam logic [TRW-1:0]     TR_LAST = TRW'(MAX_TRY - 1);

    // state and datapath registers
    sec_state_t          st_q, st_d, ret_q, ret_d;
    logic [NUM_SECT-1:0] mask_q, mask_d;
    logic [SW-1:0]       cur_q, cur_d;
    logic [SECT_AW-1:0]  ba_q, ba_d;
    logic [PCW-1:0]      pc_q, pc_d;
    logic [TRW-1:0]      tr_q, tr_d;
    logic                tog_q;
    logic [DW-1:0]       rd_q;

    // command decode
    logic          is_erase, is_susp, is_resume, is_reset, is_prog;
    logic [SW-1:0] cmd_sect, rd_sect;
    logic [NUM_SECT-1:0] cmd_bit, cur_bit;

    assign is_erase  = cmd_valid && cmd_op == OP_ERASE;
    assign is_susp   = cmd_valid && cmd_op == OP_SUSP;
    assign is_resume = cmd_valid && cmd_op == OP_RESUME;
    assign is_reset  = cmd_valid && cmd_op == OP_RESET;
    assign is_prog   = cmd_valid && cmd_op == OP_PROG;
    assign cmd_sect  = cmd_addr[AW-1:SECT_AW];
    assign rd_sect   = rd_addr[AW-1:SECT_AW];
    assign cmd_bit   = NUM_SECT'(1) << cmd_sect;
    assign cur_bit   = NUM_SECT'(1) << cur_q;

    // window timer
    logic win_restart, win_expired;
    assign win_restart = is_erase && (st_q == ST_READ || st_q == ST_WIN);

    sec_window_timer #(.LIMIT(WINDOW_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (win_restart),
        .run     (st_q == ST_WIN),
        .expired (win_expired)
    );

    // next-sector picker: while filling, look past the current sector
    logic [NUM_SECT-1:0] pick_in;
    logic [SW-1:0]       pick_idx;
    logic                pick_any;
    assign pick_in = (st_q == ST_FILL) ? (mask_q & ~cur_bit) : mask_q;

    sec_low_pick #(.N(NUM_SECT), .IW(SW)) u_pick (
        .mask (pick_in),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    // array
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    sec_byte_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    // next-state and counter logic
    always_comb begin
        st_d   = st_q;
        ret_d  = ret_q;
        mask_d = mask_q;
        cur_d  = cur_q;
        ba_d   = ba_q;
        pc_d   = pc_q;
        tr_d   = tr_q;
        unique case (st_q)
            ST_READ: begin
                if (is_erase) begin
                    mask_d = cmd_bit;
                    st_d   = ST_WIN;
                end
            end
            ST_WIN: begin
                if (is_erase) begin
                    mask_d = mask_q | cmd_bit;
                end else if (is_susp) begin
                    st_d  = ST_SUSP;
                    ret_d = ST_ZERO;
                    cur_d = pick_idx;
                    ba_d  = '0;
                    pc_d  = '0;
                    tr_d  = '0;
                end else if (is_resume) begin
                    st_d = ST_WIN;
                end else if (cmd_valid) begin
                    st_d   = ST_READ;
                    mask_d = '0;
                end else if (win_expired) begin
                    st_d  = ST_ZERO;
                    cur_d = pick_idx;
                    ba_d  = '0;
                    pc_d  = '0;
                    tr_d  = '0;
                end
            end
            ST_ZERO, ST_PULSE, ST_FILL: begin
                if (is_reset) begin
                    st_d   = ST_READ;
                    mask_d = '0;
                end else if (is_susp) begin
                    st_d  = ST_SUSP;
                    ret_d = st_q;
                end else if (st_q == ST_ZERO) begin
                    ba_d = ba_q + 1'b1;
                    if (ba_q == BA_LAST) begin
                        st_d = ST_PULSE;
                        pc_d = '0;
                    end
                end else if (st_q == ST_PULSE) begin
                    if (pc_q == PC_LAST) begin
                        pc_d = '0;
                        if (!fail_sect[cur_q]) begin
                            st_d = ST_FILL;
                            ba_d = '0;
                        end else if (tr_q == TR_LAST) begin
                            st_d = ST_FAIL;
                        end else begin
                            tr_d = tr_q + 1'b1;
                        end
                    end else begin
                        pc_d = pc_q + 1'b1;
                    end
                end else begin
                    ba_d = ba_q + 1'b1;
                    if (ba_q == BA_LAST) begin
                        mask_d = mask_q & ~cur_bit;
                        if (pick_any) begin
                            st_d  = ST_ZERO;
                            cur_d = pick_idx;
                            tr_d  = '0;
                        end else begin
                            st_d = ST_READ;
                        end
                    end
                end
            end
            ST_SUSP: begin
                if (is_resume) begin
                    st_d = ret_q;
                end else if (is_reset) begin
                    st_d   = ST_READ;
                    mask_d = '0;
                end
            end
            ST_FAIL: begin
                if (is_reset) begin
                    st_d   = ST_READ;
                    mask_d = '0;
                end
            end
            default: begin
                st_d   = ST_READ;
                mask_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_READ;
            ret_q  <= ST_ZERO;
            mask_q <= '0;
            cur_q  <= '0;
            ba_q   <= '0;
            pc_q   <= '0;
            tr_q   <= '0;
        end else begin
            st_q   <= st_d;
            ret_q  <= ret_d;
            mask_q <= mask_d;
            cur_q  <= cur_d;
            ba_q   <= ba_d;
            pc_q   <= pc_d;
            tr_q   <= tr_d;
        end
    end

    // array write outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = {cur_q, ba_q};
        mem_wdata = '0;
        unique case (st_q)
            ST_ZERO: begin
                mem_we    = !is_reset && !is_susp;
                mem_wdata = '0;
            end
            ST_FILL: begin
                mem_we    = !is_reset && !is_susp;
                mem_wdata = '1;
            end
            ST_READ: begin
                mem_we    = is_prog;
                mem_waddr = cmd_addr;
                mem_wdata = cmd_data;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end

    // read port: array data or status byte, toggle bit advances per status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            tog_q <= 1'b0;
        end else if (rd_en) begin
            unique case (st_q)
                ST_READ: begin
                    rd_q <= mem_rdata;
                end
                ST_SUSP: begin
                    rd_q <= mask_q[rd_sect] ? status_byte(tog_q, 1'b0, 1'b1) : mem_rdata;
                end
                ST_WIN: begin
                    rd_q  <= status_byte(tog_q, 1'b0, 1'b0);
                    tog_q <= ~tog_q;
                end
                ST_FAIL: begin
                    rd_q  <= status_byte(tog_q, 1'b1, 1'b1);
                    tog_q <= ~tog_q;
                end
                default: begin
                    rd_q  <= status_byte(tog_q, 1'b0, 1'b1);
                    tog_q <= ~tog_q;
                end
            endcase
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/sec_erase_chk.sv
module sec_erase_chk
    import sec_erase_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int SW       = 3
) (
    input logic                clk,
    input logic                rst_n,
    input sec_state_t          st_q,
    input logic [NUM_SECT-1:0] mask_q,
    input logic [SW-1:0]       cur_q,
    input logic                tog_q,
    input logic                cmd_valid,
    input logic [2:0]          cmd_op,
    input logic                rd_en,
    input logic [DW-1:0]       rd_data
);
    // R3
    win_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WIN && rd_en) |=> (rd_data[3] == 1'b0 && rd_data[7] == 1'b0));

    // R5
    win_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WIN && cmd_valid && cmd_op == OP_PROG) |=> (st_q == ST_READ && mask_q == '0));

    // R7
    pulse_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PULSE && rd_en && $past(st_q == ST_PULSE && rd_en))
        |=> (rd_data[6] != $past(rd_data[6])));

    // R9
    susp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SUSP && rd_en) |=> (tog_q == $past(tog_q)));

    // R8
    busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_ZERO, ST_PULSE, ST_FILL, ST_SUSP, ST_FAIL})
        |=> ((mask_q & ~$past(mask_q)) == '0));

    // R12
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FAIL && !(cmd_valid && cmd_op == OP_RESET)) |=> (st_q == ST_FAIL));

    // R6
    wr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ZERO || st_q == ST_FILL) |-> mask_q[cur_q]);
endmodule

bind sec_erase_ctl sec_erase_chk #(.NUM_SECT(NUM_SECT), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .mask_q    (mask_q),
    .cur_q     (cur_q),
    .tog_q     (tog_q),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
);

// File: tb/sim_sec_erase_ctl.sv
module sim_sec_erase_ctl;
    localparam int NS = 4;
    localparam int SAW = 3;
    localparam int W = 12;
    localparam int E = 6;
    localparam int MT = 3;
    localparam int B = 1 << SAW;
    localparam int AW = 2 + SAW;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [AW-1:0] cmd_addr = 0;
    logic [7:0] cmd_data = 0;
    logic [NS-1:0] fail_sect = 0;
    logic rd_en = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [7:0] rd_data;

    int total = 0, bad = 0, cyc = 0, c_cmd = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_erase_ctl #(.NUM_SECT(NS), .SECT_AW(SAW), .WINDOW_CYC(W), .ERASE_CYC(E), .MAX_TRY(MT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .fail_sect(fail_sect), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    function automatic logic [AW-1:0] ad(input int s, input int o);
        return AW'((s << SAW) + o);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input logic [7:0] m);
        total++;
        if ((act & m) !== (exp & m)) begin
            bad++;
            $display("FAIL %s act=%h exp=%h mask=%h", tag, act, exp, m);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_valid = 0;
        c_cmd = cyc;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(ad(0, 0), d); chk("R1 reset byte s0", d, 8'hFF, 8'hFF);
        rd(ad(3, 7), d); chk("R1 reset byte s3", d, 8'hFF, 8'hFF);
    endtask

    task automatic t_prog();
        logic [7:0] d;
        do_cmd(3'd5, ad(0, 0), 8'h11);
        rd(ad(0, 0), d); chk("R2 program s0", d, 8'h11, 8'hFF);
        do_cmd(3'd5, ad(1, 2), 8'h22);
        do_cmd(3'd5, ad(2, 5), 8'h5A);
        do_cmd(3'd5, ad(3, 7), 8'h3C);
        rd(ad(1, 2), d); chk("R2 program s1", d, 8'h22, 8'hFF);
        rd(ad(2, 5), d); chk("R2 program s2", d, 8'h5A, 8'hFF);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        do_cmd(3'd1, ad(2, 0), 8'h00);
        repeat (3) @(negedge clk);
        do_cmd(3'd5, ad(2, 5), 8'h00);
        rd(ad(3, 7), d); chk("R5 abort to read mode", d, 8'h3C, 8'hFF);
        repeat (W + 40) @(negedge clk);
        rd(ad(2, 5), d); chk("R5 no erase and no write", d, 8'h5A, 8'hFF);
    endtask

    task automatic t_single();
        logic [7:0] a, b;
        int c0, dn;
        do_cmd(3'd1, ad(0, 0), 8'h00);
        c0 = c_cmd;
        rd(ad(0, 0), a); chk("R3 window status", a, 8'h00, 8'hB8);
        rd(ad(0, 0), b); chk("R7 toggle in window", {7'b0, b[6]}, {7'b0, ~a[6]}, 8'h01);
        wait_to(c0 + W - 1);
        rd(ad(0, 0), a); chk("R4 timer flag still 0", a, 8'h00, 8'h08);
        rd(ad(0, 0), a); chk("R4 timer flag 1 at expiry", a, 8'h08, 8'hB8);
        wait_to(c0 + W + B + 2);
        rd(ad(0, 0), a); rd(ad(0, 0), b);
        chk("R7 toggle in pulse", {7'b0, b[6]}, {7'b0, ~a[6]}, 8'h01);
        dn = c0 + W + 2 * B + E;
        wait_to(dn - 1);
        rd(ad(0, 0), a); chk("R6 busy one edge before done", a, 8'h08, 8'hB8);
        rd(ad(0, 0), a); chk("R6 sector0 erased on time", a, 8'hFF, 8'hFF);
        for (int i = 0; i < B; i++) begin
            rd(ad(0, i), a); chk("R6 sector0 all FF", a, 8'hFF, 8'hFF);
        end
        rd(ad(1, 2), a); chk("R6 unselected s1 kept", a, 8'h22, 8'hFF);
    endtask

    task automatic t_multi();
        logic [7:0] a, b;
        int c1, f1, es, er, dn;
        do_cmd(3'd1, ad(3, 0), 8'h00);
        repeat (4) @(negedge clk);
        do_cmd(3'd1, ad(1, 0), 8'h00);
        c1 = c_cmd;
        wait_to(c1 + W - 1);
        rd(ad(1, 0), a); chk("R4 restarted window", a, 8'h00, 8'h08);
        f1 = c1 + W + 2 * B + E;
        wait_to(f1 + 1);
        do_cmd(3'd2, ad(3, 0), 8'h00);
        es = c_cmd;
        rd(ad(1, 2), a); chk("R6 lower sector first done", a, 8'hFF, 8'hFF);
        rd(ad(3, 0), a); chk("R9 selected sector status", a, 8'h08, 8'hB8);
        rd(ad(3, 0), b); chk("R9 toggle frozen", {7'b0, b[6]}, {7'b0, a[6]}, 8'h01);
        rd(ad(2, 5), a); chk("R9 other sector valid", a, 8'h5A, 8'hFF);
        do_cmd(3'd5, ad(0, 1), 8'h77);
        rd(ad(0, 1), a); chk("R9 program refused", a, 8'hFF, 8'hFF);
        do_cmd(3'd3, ad(0, 0), 8'h00);
        er = c_cmd;
        dn = c1 + W + 2 * (2 * B + E) + (er - es + 1);
        wait_to(dn - 1);
        rd(ad(3, 7), a); chk("R10 still busy before shifted end", a, 8'h08, 8'hB8);
        rd(ad(3, 7), a); chk("R10 resumed erase completes", a, 8'hFF, 8'hFF);
        rd(ad(2, 5), a); chk("R6 unselected s2 kept", a, 8'h5A, 8'hFF);
    endtask

    task automatic t_busy();
        logic [7:0] a;
        int c0, dn;
        do_cmd(3'd5, ad(0, 3), 8'h44);
        do_cmd(3'd1, ad(2, 0), 8'h00);
        c0 = c_cmd;
        wait_to(c0 + W + B + 2);
        do_cmd(3'd5, ad(0, 3), 8'h99);
        do_cmd(3'd1, ad(0, 0), 8'h00);
        do_cmd(3'd3, ad(0, 0), 8'h00);
        dn = c0 + W + 2 * B + E;
        wait_to(dn - 1);
        rd(ad(2, 5), a); chk("R8 timing unchanged busy", a, 8'h08, 8'hB8);
        rd(ad(2, 5), a); chk("R8 timing unchanged done", a, 8'hFF, 8'hFF);
        rd(ad(0, 3), a); chk("R8 program/erase ignored", a, 8'h44, 8'hFF);
        do_cmd(3'd5, ad(3, 1), 8'h12);
        do_cmd(3'd1, ad(3, 0), 8'h00);
        c0 = c_cmd;
        wait_to(c0 + W + B + 2);
        do_cmd(3'd4, ad(0, 0), 8'h00);
        rd(ad(3, 1), a); chk("R8 reset to read, prefilled 00", a, 8'h00, 8'hFF);
        rd(ad(3, 7), a); chk("R6 prefill reached last byte", a, 8'h00, 8'hFF);
    endtask

    task automatic t_win_susp();
        logic [7:0] a;
        int es, er, dn;
        do_cmd(3'd5, ad(1, 4), 8'h00);
        do_cmd(3'd1, ad(1, 0), 8'h00);
        repeat (3) @(negedge clk);
        do_cmd(3'd2, ad(1, 0), 8'h00);
        es = c_cmd;
        wait_to(es + W + 10);
        rd(ad(0, 3), a); chk("R11 window ended, other sector data", a, 8'h44, 8'hFF);
        rd(ad(1, 4), a); chk("R11 suspended status timer 1", a, 8'h08, 8'hB8);
        do_cmd(3'd3, ad(0, 0), 8'h00);
        er = c_cmd;
        dn = er + 2 * B + E;
        wait_to(dn - 1);
        rd(ad(1, 4), a); chk("R11 busy before end", a, 8'h08, 8'hB8);
        rd(ad(1, 4), a); chk("R11 erase from resume", a, 8'hFF, 8'hFF);
    endtask

    task automatic t_fail();
        logic [7:0] a;
        int c0, ft;
        fail_sect = 4'b0100;
        do_cmd(3'd5, ad(2, 1), 8'h0F);
        do_cmd(3'd1, ad(2, 0), 8'h00);
        c0 = c_cmd;
        ft = c0 + W + B + MT * E;
        wait_to(ft - 1);
        rd(ad(2, 0), a); chk("R12 no error before limit", a, 8'h08, 8'hB8);
        rd(ad(2, 0), a); chk("R12 error at limit", a, 8'h28, 8'hB8);
        repeat (20) @(negedge clk);
        do_cmd(3'd2, ad(2, 0), 8'h00);
        rd(ad(2, 0), a); chk("R12 error held", a, 8'h28, 8'hB8);
        do_cmd(3'd4, ad(0, 0), 8'h00);
        rd(ad(2, 1), a); chk("R12 reset leaves failed sector at 00", a, 8'h00, 8'hFF);
        fail_sect = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_prog();
                t_abort();
                t_single();
                t_multi();
                t_busy();
                t_win_susp();
                t_fail();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog expired act=%0d exp=done", cyc);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule